// File: doc/BRIEF.md
# Speculative Store-Forwarding Cache

This block is a very small direct-mapped cache that exists only to pass values between instructions while a core runs ahead speculatively past a long-latency miss. When a store is pseudo-retired in that mode, its data and its poison flag (set when the value depends on an unresolved miss) are written here rather than to architectural memory. A later speculative load presents its address and receives the cached word, its poison flag and a hit indication. On a miss the load falls back to the normal memory path. The core pulses a clear input when speculative mode ends, which empties the whole cache at once.

Because every result it returns is speculative, the cache is allowed to be wrong: a newer store to a line that is already occupied simply replaces it, with no write-back. Architectural memory is never written by this block. The lookup is combinational against the stored state, so a store takes effect at the clock edge and is visible to loads from the following cycle on.

The block has no control state machine: the only state is the per-line valid, tag, data and poison storage, and the only transitions are fill on a store, invalidation on clear and invalidation on reset.

Top module: `rfc_store_fwd_cache`

## Requirements
- R1: After reset every line is invalid, so a load to any address reports ld_hit low.
- R2: After a store with st_en high (and spec_clr low) at a clock edge, a load to the same address reports ld_hit high and returns the stored data on ld_data.
- R3: A load whose line index matches a valid line but whose tag differs reports ld_hit low.
- R4: Whenever ld_hit is low, ld_data reads as zero and ld_inv reads as low.
- R5: A store to an index already holding a different tag replaces that line with no write-back; the old address then misses and the new one hits.
- R6: A single cycle with spec_clr high invalidates all lines, so every load in the following cycles misses until a new store.
- R7: A store presented in the same cycle as spec_clr is dropped; its address misses afterwards.
- R8: A load and a store to the same address in the same cycle return the contents held before that store (miss if empty, old data if filled).
- R9: The poison flag st_inv is stored per line and returned on ld_inv with the hit; a later store to the line replaces it.
- R10: Addresses are word addresses; the line index is the low log2(LINES) bits (bits 3:0 with 16 lines) and the tag is every remaining upper bit, so addresses differing only in the top bit do not alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, invalidates all lines |
| spec_clr | input | 1 | Pulsed when speculative mode ends; invalidates all lines |
| st_en | input | 1 | Store write strobe from a pseudo-retired store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_inv | input | 1 | Poison flag of the store data |
| ld_addr | input | ADDR_W | Load word address for lookup |
| ld_hit | output | 1 | Load found a valid line with a matching tag |
| ld_data | output | DATA_W | Forwarded data, zero on a miss |
| ld_inv | output | 1 | Forwarded poison flag, low on a miss |

## Verification
The embedded properties watch every cycle for an empty cache right after reset and after any clear, for a store being visible at its own address in the next cycle, for a same-index different-tag lookup missing, and for a miss never exposing data or poison. Ordering effects that need a chosen sequence of addresses are left to the bench's scenarios: same-cycle store and load returning old contents, a dropped store under clear, replacement of an occupied line, poison overwrite, full fill of all lines and top-bit tag distinction.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    // Default geometry of the speculative store-forwarding cache
    localparam int RFC_ADDR_W = 32;
    localparam int RFC_DATA_W = 32;
    localparam int RFC_LINES  = 16;
endpackage

// File: rtl/rfc_addr_split.sv
// Splits a word address into line index (low bits) and tag (upper bits). R10
module rfc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    assign idx = addr[IDX_W-1:0];
    assign tag = addr[ADDR_W-1:IDX_W];
endmodule

// File: rtl/rfc_line_array.sv
// Line storage: valid, tag, data and poison flag per line.
module rfc_line_array #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_inv,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv
);
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  wr_sel;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  inv_q;

    // One-hot write select; clear suppresses any store in the same cycle (R7)
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_sel
            assign wr_sel[g] = wr_en && !clr && (wr_idx == IDX_W'(g));
        end
    endgenerate

    // Valid bits: reset and clear empty every line in one cycle (R1, R6)
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q | wr_sel;
        end
    end

    // Payload: an occupied line is simply overwritten, no write-back (R5, R9)
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (wr_sel[i]) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
                inv_q[i]  <= wr_inv;
            end
        end
    end

    // Combinational read of the contents held before this cycle's edge (R8)
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_inv   = inv_q[rd_idx];

    // R1: the cycle after reset releases, no line is valid
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0));

    // R6: the cycle after a clear, no line is valid, even if a store came with it
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (valid_q == '0));
endmodule

// File: rtl/rfc_lookup.sv
// Tag compare and output gating for the load port.
module rfc_lookup #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  logic              line_inv,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              hit,
    output logic [DATA_W-1:0] data,
    output logic              inv
);
    always_comb begin
        hit  = line_valid && (line_tag == req_tag); // R3 mismatch misses
        data = hit ? line_data : '0;                // R4 zero on miss
        inv  = hit && line_inv;
    end
endmodule

// File: rtl/rfc_store_fwd_cache.sv
module rfc_store_fwd_cache #(
    parameter int ADDR_W = rfc_pkg::RFC_ADDR_W,
    parameter int DATA_W = rfc_pkg::RFC_DATA_W,
    parameter int LINES  = rfc_pkg::RFC_LINES,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spec_clr,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_inv,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_inv
);
    logic [IDX_W-1:0]  st_idx, ld_idx;
    logic [TAG_W-1:0]  st_tag, ld_tag;
    logic              rd_valid, rd_inv;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;

    rfc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_st_split (
        .addr(st_addr), .idx(st_idx), .tag(st_tag)
    );

    rfc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ld_split (
        .addr(ld_addr), .idx(ld_idx), .tag(ld_tag)
    );

    rfc_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .clr      (spec_clr),
        .wr_en    (st_en),
        .wr_idx   (st_idx),
        .wr_tag   (st_tag),
        .wr_data  (st_data),
        .wr_inv   (st_inv),
        .rd_idx   (ld_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_inv   (rd_inv)
    );

    rfc_lookup #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
        .line_valid (rd_valid),
        .line_tag   (rd_tag),
        .line_data  (rd_data),
        .line_inv   (rd_inv),
        .req_tag    (ld_tag),
        .hit        (ld_hit),
        .data       (ld_data),
        .inv        (ld_inv)
    );

    // R2 and R9: a store accepted at the last edge is returned at its own address
    a_r2_store_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(st_en && !spec_clr && !rst) && (ld_addr == $past(st_addr)))
        |-> (ld_hit && (ld_data == $past(st_data)) && (ld_inv == $past(st_inv))));

    // R3: same index as the last store but a different tag must miss
    a_r3_tag_mismatch_miss: assert property (@(posedge clk) disable iff (rst)
        ($past(st_en && !spec_clr && !rst)
         && (ld_addr[IDX_W-1:0] == $past(st_addr[IDX_W-1:0]))
         && (ld_addr[ADDR_W-1:IDX_W] != $past(st_addr[ADDR_W-1:IDX_W])))
        |-> !ld_hit);

    // R4: a miss never exposes data or poison
    a_r4_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        !ld_hit |-> ((ld_data == '0) && !ld_inv));
endmodule

// File: tb/tb_rfc_store_fwd_cache.sv
`timescale 1ns/1ps
module tb_rfc_store_fwd_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spec_clr = 1'b0;
    logic        st_en = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_inv = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        ld_inv;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rfc_store_fwd_cache dut (
        .clk(clk), .rst(rst), .spec_clr(spec_clr), .st_en(st_en),
        .st_addr(st_addr), .st_data(st_data), .st_inv(st_inv),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_inv(ld_inv)
    );

    typedef struct packed {
        logic        clr;
        logic        s_en;
        logic [31:0] s_addr;
        logic [31:0] s_data;
        logic        s_inv;
        logic [31:0] l_addr;
        logic        e_hit;
        logic [31:0] e_data;
        logic        e_inv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    // Inputs apply during the cycle; expectations are the same-cycle lookup
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000005,1'b0,32'h0,1'b0,4'd1},        // R1 empty
        '{1'b0,1'b1,32'h5,32'hAAAA0005,1'b0,32'h00000005,1'b0,32'h0,1'b0,4'd8}, // R8 old (empty)
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000005,1'b1,32'hAAAA0005,1'b0,4'd2}, // R2
        '{1'b0,1'b1,32'h23,32'h00001234,1'b1,32'h00000015,1'b0,32'h0,1'b0,4'd3},// R3 idx5 tag1
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000023,1'b1,32'h00001234,1'b1,4'd9}, // R9 poison
        '{1'b0,1'b1,32'h15,32'h0000BEEF,1'b0,32'h00000005,1'b1,32'hAAAA0005,1'b0,4'd8}, // R8 old data
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000005,1'b0,32'h0,1'b0,4'd5},        // R5 replaced
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000015,1'b1,32'h0000BEEF,1'b0,4'd5}, // R5 new line
        '{1'b0,1'b1,32'h5,32'h00000077,1'b1,32'h00000023,1'b1,32'h00001234,1'b1,4'd2},
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000005,1'b1,32'h00000077,1'b1,4'd9}, // R9 overwrite
        '{1'b1,1'b1,32'h2F,32'h00000099,1'b0,32'h00000023,1'b1,32'h00001234,1'b1,4'd8},
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000023,1'b0,32'h0,1'b0,4'd6},        // R6
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h0000002F,1'b0,32'h0,1'b0,4'd7},        // R7 dropped
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h00000005,1'b0,32'h0,1'b0,4'd4},        // R4 quiet miss
        '{1'b0,1'b1,32'hFFFFFFFF,32'h0000CAFE,1'b0,32'h00000000,1'b0,32'h0,1'b0,4'd1},
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'hFFFFFFFF,1'b1,32'h0000CAFE,1'b0,4'd10},// R10
        '{1'b0,1'b0,32'h0,32'h0,1'b0,32'h7FFFFFFF,1'b0,32'h0,1'b0,4'd10}        // R10 top bit
    };

    task automatic check(input string req, input logic e_hit,
                         input logic [31:0] e_data, input logic e_inv);
        checks++;
        if (ld_hit !== e_hit || ld_data !== e_data || ld_inv !== e_inv) begin
            errors++;
            $display("FAIL %s addr=%h: got hit=%b data=%h inv=%b, expected hit=%b data=%h inv=%b",
                     req, ld_addr, ld_hit, ld_data, ld_inv, e_hit, e_data, e_inv);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", 1'b0, 32'h0, 1'b0);

        // Vector table: drive at negedge, sample 1 ns later, edge commits stores
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            spec_clr = VECS[v].clr;
            st_en    = VECS[v].s_en;
            st_addr  = VECS[v].s_addr;
            st_data  = VECS[v].s_data;
            st_inv   = VECS[v].s_inv;
            ld_addr  = VECS[v].l_addr;
            #1 check($sformatf("R%0d vec%0d", VECS[v].req, v),
                     VECS[v].e_hit, VECS[v].e_data, VECS[v].e_inv);
        end
        @(negedge clk);
        st_en = 1'b0; spec_clr = 1'b0;

        // Fill every line with a distinct tag, then read all back (R2, R9)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            st_en = 1'b1;
            st_addr = ((32'h100 + 32'(i)) << 4) | 32'(i);
            st_data = 32'hD000_0000 + 32'(i);
            st_inv = i[0];
        end
        @(negedge clk);
        st_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            ld_addr = ((32'h100 + 32'(i)) << 4) | 32'(i);
            #0.1 check("R2 fill", 1'b1, 32'hD000_0000 + 32'(i), i[0]);
        end

        // One-cycle clear empties all lines (R6)
        @(negedge clk);
        spec_clr = 1'b1;
        @(negedge clk);
        spec_clr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            ld_addr = ((32'h100 + 32'(i)) << 4) | 32'(i);
            #0.1 check("R6 all", 1'b0, 32'h0, 1'b0);
        end

        // Reset in mid-run empties the cache (R1)
        st_en = 1'b1; st_addr = 32'h9; st_data = 32'h5555; st_inv = 1'b0;
        @(negedge clk);
        st_en = 1'b0; ld_addr = 32'h9;
        #0.1 check("R2 pre-reset", 1'b1, 32'h5555, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #0.1 check("R1 after reset", 1'b0, 32'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule